// File: doc/BRIEF.md
# Queued SPI Master Transfer Engine

This block is an SPI master that walks a queue of commands kept in three small on-chip register files: command, transmit and receive. Software fills the command and transmit entries through a simple write port, sets a start index and an end index, then pulses `go`. The engine runs every entry from the start index up to and including the end index, wrapping past the last slot back to slot 0. For each entry it drives the chip-select pattern named in the command, shifts the transmit word out on MOSI with the most significant bit first, and samples MISO. The received word goes into the receive file at the same index.

Each word is 8 bits long unless its command sets a per-entry flag. In that case the length comes from a shared length setting, clamped to the range 8 to 16. SCK polarity and phase are configurable, and the SCK half-period is a programmable number of system clocks. While the engine is idle, every pin takes its level from a set of port-value inputs. Software loads these with the inactive SCK and chip-select levels, so the hand-off between engine and port values makes no glitch.

A low level on the slave-select input while master mode is enabled is a mode fault. It aborts the queue at once and returns the pins to their port values. It also sets a sticky flag that software clears. A wired-OR enable turns every output into open-drain drive, which only ever pulls low.

Top module: `qspi_engine`

## Requirements
- R1: Every word leaves MOSI with its most significant bit first, and the slave-side capture of the word equals the transmit entry masked to the word length.
- R2: A command entry is 5 bits: bit 4 is the length-select flag and bits 3:0 are the chip-select pattern. With the flag clear the word is 8 bits. With the flag set it is `cfg_bits`, where values below 8 become 8 and values above 16 become 16. A word of N bits makes exactly 2N SCK transitions.
- R3: SCK rests at `cfg_cpol` inside a run whenever no word is shifting. With `cfg_cpha`=0 MISO is sampled on the leading (first) edge of each bit; with `cfg_cpha`=1 it is sampled on the trailing edge. The received bits are stored right-aligned with zeros above.
- R4: Each SCK half-period lasts `cfg_div` system clocks, and a value of 0 behaves as 1.
- R5: A run transfers indices start, start+1, … up to and including end, modulo 16. Each received word is written to the receive slot of its own index, and slots outside the run keep their contents.
- R6: `busy` rises on the clock edge that takes an accepted `go` and falls when the end entry completes. `done` is cleared by an accepted `go` and set when the end entry completes. `busy` and `done` are never high together.
- R7: While SCK is toggling for an entry, the chip-select outputs hold that entry's pattern.
- R8: Whenever `busy` is low, `sck`, `mosi` and `pcs` equal `port_sck`, `port_mosi` and `port_pcs`.
- R9: `ss_n` low while `master_en` is high sets `mode_fault` and clears `busy` on the next clock edge. The word in flight is dropped and its receive slot is not written. `mode_fault` stays set until `fault_clr` is applied. A fault wins over a `fault_clr` or a `go` in the same cycle. No fault is raised when `master_en` is low.
- R10: `go` is ignored while `mode_fault` is set, while `master_en` is low, or while `busy` is high.
- R11: With `wired_or` high, each output enable (`sck_oe`, `mosi_oe`, `pcs_oe`) is the inverse of its pin level, so a pin is never driven high. With `wired_or` low, all enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Write strobe for the command or transmit file |
| host_sel | input | 1 | 0 selects the command file, 1 selects the transmit file |
| host_addr | input | 4 | Entry index for the write |
| host_wdata | input | 16 | Write data (the command file uses bits 4:0) |
| rx_addr | input | 4 | Receive file read index |
| rx_rdata | output | 16 | Receive file read data |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_bits | input | 5 | Word length used when an entry's length flag is set |
| cfg_div | input | 8 | SCK half-period in system clocks |
| master_en | input | 1 | Master mode enable |
| wired_or | input | 1 | Open-drain drive for all outputs |
| start_ptr | input | 4 | First queue index of a run |
| end_ptr | input | 4 | Last queue index of a run |
| go | input | 1 | Start a run |
| fault_clr | input | 1 | Clear the mode-fault flag |
| port_sck | input | 1 | SCK level while idle |
| port_mosi | input | 1 | MOSI level while idle |
| port_pcs | input | 4 | Chip-select levels while idle |
| ss_n | input | 1 | Slave-select input, active low |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock pin level |
| sck_oe | output | 1 | SCK drive enable |
| mosi | output | 1 | Serial data out pin level |
| mosi_oe | output | 1 | MOSI drive enable |
| pcs | output | 4 | Chip-select pin levels |
| pcs_oe | output | 4 | Chip-select drive enables |
| busy | output | 1 | Queue running |
| done | output | 1 | End entry completed |
| mode_fault | output | 1 | Sticky mode-fault flag |

## Verification
The mode-fault set path shares its cycle with two other control actions: a software clear of the flag, and a `go` that would start a run. The bench drives `ss_n` low in the same cycle as `fault_clr`, and separately in the same cycle as `go`. On the next cycle it expects `mode_fault` high and `busy` low in both cases. A third collision, a fault arriving in the middle of a word, is judged at the ports: the pins must fall back to their port values, and the receive slot of the aborted entry must still hold its earlier word.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int unsigned MAXW = 16;
  localparam int unsigned MINW = 8;
  localparam int unsigned CSN  = 4;
  localparam int unsigned LENW = 5;

  typedef struct packed {
    logic            len_sel;
    logic [CSN-1:0]  cs;
  } cmd_t;

  localparam int unsigned CMDW = $bits(cmd_t);

  // Effective word length for one command entry.
  function automatic logic [LENW-1:0] word_len(input logic len_sel,
                                                input logic [LENW-1:0] bits);
    if (!len_sel)               return LENW'(MINW);
    if (bits < LENW'(MINW))     return LENW'(MINW);
    if (bits > LENW'(MAXW))     return LENW'(MAXW);
    return bits;
  endfunction
endpackage

// File: rtl/qspi_regfile.sv
module qspi_regfile #(
  parameter int unsigned W  = 16,
  parameter int unsigned D  = 16,
  parameter int unsigned AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 5,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          cpha,
  input  logic [CW-1:0] half,
  input  logic [LW-1:0] nbits,
  input  logic [DW-1:0] txd,
  input  logic          miso,
  output logic          phase,
  output logic          mosi,
  output logic          active,
  output logic          done,
  output logic [DW-1:0] rxd
);
  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_XFER, S_TRAIL} st_t;
  localparam logic [LW:0]   EDGE_ONE = 1;
  localparam logic [CW-1:0] CNT_ONE  = 1;

  st_t           st;
  logic [CW-1:0] cnt, half_q;
  logic [LW:0]   edges, nxt_edge;
  logic [LW-1:0] nb_q;
  logic          cpha_q, tick, smp, last;
  logic [DW-1:0] sh, rx;

  assign tick     = (cnt == half_q - CNT_ONE);
  assign nxt_edge = edges + EDGE_ONE;
  assign smp      = cpha_q ? ~nxt_edge[0] : nxt_edge[0];
  assign last     = (nxt_edge == {nb_q, 1'b0});
  assign mosi     = sh[DW-1];
  assign rxd      = rx;
  assign active   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; half_q <= CNT_ONE; edges <= '0; nb_q <= '0;
      cpha_q <= 1'b0; sh <= '0; rx <= '0; phase <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
        phase <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            sh     <= txd << (LW'(DW) - nbits);
            rx     <= '0;
            cnt    <= '0;
            edges  <= '0;
            phase  <= 1'b0;
            nb_q   <= nbits;
            cpha_q <= cpha;
            half_q <= half;
            st     <= S_LEAD;
          end
          S_LEAD: begin
            cnt <= tick ? '0 : cnt + CNT_ONE;
            if (tick) st <= S_XFER;
          end
          S_XFER: begin
            cnt <= tick ? '0 : cnt + CNT_ONE;
            if (tick) begin
              phase <= ~phase;
              edges <= nxt_edge;
              if (smp)                  rx <= {rx[DW-2:0], miso};
              else if (nxt_edge != EDGE_ONE) sh <= sh << 1;
              if (last) st <= S_TRAIL;
            end
          end
          default: begin
            cnt <= tick ? '0 : cnt + CNT_ONE;
            if (tick) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
  import qspi_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIVW  = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic            host_sel,
  input  logic [AW-1:0]   host_addr,
  input  logic [MAXW-1:0] host_wdata,
  input  logic [AW-1:0]   rx_addr,
  output logic [MAXW-1:0] rx_rdata,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic [LENW-1:0] cfg_bits,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            master_en,
  input  logic            wired_or,
  input  logic [AW-1:0]   start_ptr,
  input  logic [AW-1:0]   end_ptr,
  input  logic            go,
  input  logic            fault_clr,
  input  logic            port_sck,
  input  logic            port_mosi,
  input  logic [CSN-1:0]  port_pcs,
  input  logic            ss_n,
  input  logic            miso,
  output logic            sck,
  output logic            sck_oe,
  output logic            mosi,
  output logic            mosi_oe,
  output logic [CSN-1:0]  pcs,
  output logic [CSN-1:0]  pcs_oe,
  output logic            busy,
  output logic            done,
  output logic            mode_fault
);
  localparam logic [AW-1:0]   PTR_ONE = 1;
  localparam logic [DIVW-1:0] DIV_ONE = 1;

  logic            busy_q, done_q, fault_q, issue_q;
  logic [AW-1:0]   ptr_q;
  logic [CMDW-1:0] cmd_raw;
  cmd_t            cmd_rd;
  logic [MAXW-1:0] tx_rd, sh_rxd;
  logic [DIVW-1:0] half_eff;
  logic [LENW-1:0] cur_len;
  logic            sh_phase, sh_mosi, sh_active, sh_done;
  // Named internal events (also observed by the checker)
  logic            fault_evt, go_ok, word_end, rx_we;

  assign fault_evt = master_en & ~ss_n;
  assign go_ok     = go & master_en & ~fault_q & ~busy_q;
  assign word_end  = busy_q & sh_done;
  assign rx_we     = word_end & ~fault_evt;
  assign cmd_rd    = cmd_t'(cmd_raw);
  assign cur_len   = word_len(cmd_rd.len_sel, cfg_bits);
  assign half_eff  = (cfg_div == '0) ? DIV_ONE : cfg_div;

  qspi_regfile #(.W(CMDW), .D(DEPTH)) u_cmd (
    .clk(clk), .we(host_we & ~host_sel), .waddr(host_addr),
    .wdata(host_wdata[CMDW-1:0]), .raddr(ptr_q), .rdata(cmd_raw));

  qspi_regfile #(.W(MAXW), .D(DEPTH)) u_tx (
    .clk(clk), .we(host_we & host_sel), .waddr(host_addr),
    .wdata(host_wdata), .raddr(ptr_q), .rdata(tx_rd));

  qspi_regfile #(.W(MAXW), .D(DEPTH)) u_rx (
    .clk(clk), .we(rx_we), .waddr(ptr_q),
    .wdata(sh_rxd), .raddr(rx_addr), .rdata(rx_rdata));

  qspi_shifter #(.DW(MAXW), .LW(LENW), .CW(DIVW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(issue_q), .abort(fault_evt),
    .cpha(cfg_cpha), .half(half_eff), .nbits(cur_len), .txd(tx_rd),
    .miso(miso), .phase(sh_phase), .mosi(sh_mosi), .active(sh_active),
    .done(sh_done), .rxd(sh_rxd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; fault_q <= 1'b0;
      issue_q <= 1'b0; ptr_q <= '0;
    end else begin
      issue_q <= 1'b0;
      if (fault_evt) begin
        fault_q <= 1'b1;
        busy_q  <= 1'b0;
      end else begin
        if (fault_clr) fault_q <= 1'b0;
        if (go_ok) begin
          busy_q  <= 1'b1;
          done_q  <= 1'b0;
          ptr_q   <= start_ptr;
          issue_q <= 1'b1;
        end else if (word_end) begin
          if (ptr_q == end_ptr) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ptr_q   <= ptr_q + PTR_ONE;
            issue_q <= 1'b1;
          end
        end
      end
    end
  end

  // Pin hand-off: engine values while running, port values otherwise
  assign sck  = busy_q ? (cfg_cpol ^ sh_phase) : port_sck;
  assign mosi = busy_q ? sh_mosi : port_mosi;
  assign pcs  = busy_q ? cmd_rd.cs : port_pcs;

  assign sck_oe  = ~wired_or | ~sck;
  assign mosi_oe = ~wired_or | ~mosi;
  assign pcs_oe  = {CSN{~wired_or}} | ~pcs;

  assign busy       = busy_q;
  assign done       = done_q;
  assign mode_fault = fault_q;
endmodule

// File: rtl/qspi_engine_chk.sv
module qspi_engine_chk #(parameter int unsigned CSN = 4) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           mode_fault,
  input logic           fault_evt,
  input logic           fault_clr,
  input logic           go,
  input logic           sck,
  input logic           mosi,
  input logic [CSN-1:0] pcs,
  input logic           port_sck,
  input logic           port_mosi,
  input logic [CSN-1:0] port_pcs,
  input logic           wired_or,
  input logic           sck_oe,
  input logic           mosi_oe,
  input logic [CSN-1:0] pcs_oe,
  input logic           cfg_cpol,
  input logic           sh_active
);
  a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!busy && mode_fault));

  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && !fault_clr) |=> mode_fault);

  a_r8_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == port_sck && mosi == port_mosi && pcs == port_pcs));

  a_r7_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sck != $past(sck)) |-> $stable(pcs));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_go_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode_fault) |=> !busy);

  a_r11_no_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    wired_or |-> (!(sck_oe && sck) && !(mosi_oe && mosi) && ((pcs_oe & pcs) == '0)));

  a_r3_sck_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sh_active) |-> (sck == cfg_cpol));
endmodule

bind qspi_engine qspi_engine_chk #(.CSN(qspi_pkg::CSN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode_fault(mode_fault),
  .fault_evt(fault_evt), .fault_clr(fault_clr), .go(go), .sck(sck), .mosi(mosi),
  .pcs(pcs), .port_sck(port_sck), .port_mosi(port_mosi), .port_pcs(port_pcs),
  .wired_or(wired_or), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .pcs_oe(pcs_oe),
  .cfg_cpol(cfg_cpol), .sh_active(sh_active));

// File: tb/sim_qspi_engine.sv
`timescale 1ns/1ps
module sim_qspi_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_sel = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [3:0]  rx_addr = '0;
  logic [15:0] rx_rdata;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [4:0]  cfg_bits = 5'd8;
  logic [7:0]  cfg_div = 8'd1;
  logic        master_en = 1'b1, wired_or = 1'b0;
  logic [3:0]  start_ptr = '0, end_ptr = '0;
  logic        go = 1'b0, fault_clr = 1'b0;
  logic        port_sck = 1'b0, port_mosi = 1'b0;
  logic [3:0]  port_pcs = 4'b1111;
  logic        ss_n = 1'b1;
  logic        miso, inv = 1'b0;
  logic        sck, sck_oe, mosi, mosi_oe, busy, done, mode_fault;
  logic [3:0]  pcs, pcs_oe;

  int n_cmp = 0, n_bad = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  assign miso = mosi ^ inv;   // loopback, optionally inverted

  qspi_engine u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .rx_addr(rx_addr),
    .rx_rdata(rx_rdata), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_bits(cfg_bits), .cfg_div(cfg_div), .master_en(master_en),
    .wired_or(wired_or), .start_ptr(start_ptr), .end_ptr(end_ptr), .go(go),
    .fault_clr(fault_clr), .port_sck(port_sck), .port_mosi(port_mosi),
    .port_pcs(port_pcs), .ss_n(ss_n), .miso(miso), .sck(sck), .sck_oe(sck_oe),
    .mosi(mosi), .mosi_oe(mosi_oe), .pcs(pcs), .pcs_oe(pcs_oe), .busy(busy),
    .done(done), .mode_fault(mode_fault));

  // ---------------- slave-side monitor ----------------
  logic        mon_en = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0, prev_sck = 1'b0;
  logic [3:0]  exp_cs = '0;
  logic [15:0] cap = '0;
  int          edges_m = 0, cyc = 0, last_cyc = 0, per_err = 0, pcs_err = 0, exp_half = 1;

  always @(negedge clk) begin
    cyc++;
    if (mon_en && busy && sck !== prev_sck) begin
      edges_m++;
      if ((sck != mon_cpol) != mon_cpha) cap = {cap[14:0], mosi};
      if (edges_m > 1 && (cyc - last_cyc) != exp_half) per_err++;
      if (pcs !== exp_cs) pcs_err++;
      last_cyc = cyc;
    end
    prev_sck = sck;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic read_rx(input logic [3:0] a, output logic [15:0] d);
    rx_addr = a;
    #1;
    d = rx_rdata;
  endtask

  task automatic run_queue(input logic [3:0] s, input logic [3:0] e);
    @(negedge clk);
    start_ptr = s; end_ptr = e; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk("R6 busy after go", busy, 1'b1);
    chk("R6 done cleared by go", done, 1'b0);
    while (busy) @(negedge clk);
  endtask

  function automatic int exp_len(input logic sel, input logic [4:0] b);
    if (!sel) return 8;
    if (b < 8) return 8;
    if (b > 16) return 16;
    return int'(b);
  endfunction

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [15:0] tx;
    logic        len_sel;
    logic [4:0]  bits;
    logic        cpol;
    logic        cpha;
    logic [7:0]  div;
    logic [3:0]  cs;
    logic        inv;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'h00A5, 1'b0, 5'd8,  1'b0, 1'b0, 8'd1, 4'b1110, 1'b0},
    '{16'h3C5A, 1'b1, 5'd12, 1'b1, 1'b0, 8'd2, 4'b1101, 1'b1},
    '{16'hBEEF, 1'b1, 5'd16, 1'b0, 1'b1, 8'd3, 4'b1011, 1'b0},
    '{16'h0135, 1'b1, 5'd9,  1'b1, 1'b1, 8'd1, 4'b0111, 1'b0},
    '{16'hFFFF, 1'b1, 5'd3,  1'b0, 1'b1, 8'd2, 4'b0000, 1'b1},
    '{16'h8001, 1'b1, 5'd20, 1'b1, 1'b0, 8'd0, 4'b1100, 1'b0},
    '{16'h1234, 1'b0, 5'd16, 1'b0, 1'b0, 8'd1, 4'b1001, 1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    // ---- reset state (R6, R8)
    repeat (3) @(negedge clk);
    chk("R6 busy at reset", busy, 1'b0);
    chk("R6 done at reset", done, 1'b0);
    chk("R9 fault at reset", mode_fault, 1'b0);
    chk("R8 idle pcs = port", pcs, port_pcs);
    rst_n = 1'b1;
    @(negedge clk);

    // ---- table walk: R1 R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic int n = exp_len(v.len_sel, v.bits);
      automatic logic [15:0] mask = 16'((32'h1 << n) - 1);
      host_write(1'b0, 4'(i), {11'd0, v.len_sel, v.cs});
      host_write(1'b1, 4'(i), v.tx);
      cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_bits = v.bits; cfg_div = v.div;
      port_sck = v.cpol; inv = v.inv;
      mon_cpol = v.cpol; mon_cpha = v.cpha; exp_cs = v.cs;
      exp_half = (v.div == 0) ? 1 : int'(v.div);
      cap = '0; edges_m = 0; per_err = 0; pcs_err = 0; mon_en = 1'b1;
      run_queue(4'(i), 4'(i));
      mon_en = 1'b0;
      chk("R1 MSB-first slave capture", cap & mask, v.tx & mask);
      chk("R2 edge count = 2N", edges_m, 2 * n);
      chk("R4 half-period", per_err, 0);
      chk("R7 chip-select during edges", pcs_err, 0);
      chk("R6 done after end entry", done, 1'b1);
      read_rx(4'(i), r);
      chk("R3 received word", r, (v.tx ^ {16{v.inv}}) & mask);
      chk("R8 idle sck = port", sck, port_sck);
    end

    // ---- wrap-around queue: R5
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_bits = 5'd16; cfg_div = 8'd1;
    port_sck = 1'b0; inv = 1'b0;
    host_write(1'b0, 4'd14, 16'h0011); host_write(1'b1, 4'd14, 16'hA001);
    host_write(1'b0, 4'd15, 16'h0012); host_write(1'b1, 4'd15, 16'h0B02);
    host_write(1'b0, 4'd0,  16'h0004); host_write(1'b1, 4'd0,  16'h77C3);
    host_write(1'b0, 4'd1,  16'h0018); host_write(1'b1, 4'd1,  16'hD004);
    run_queue(4'd14, 4'd1);
    read_rx(4'd14, r); chk("R5 rx slot 14", r, 16'hA001);
    read_rx(4'd15, r); chk("R5 rx slot 15", r, 16'h0B02);
    read_rx(4'd0,  r); chk("R5 rx slot 0 (8-bit)", r, 16'h00C3);
    read_rx(4'd1,  r); chk("R5 rx slot 1", r, 16'hD004);
    read_rx(4'd2,  r); chk("R5 slot outside run untouched", r, 16'hBEEF);
    chk("R6 done after wrap run", done, 1'b1);

    // ---- mode fault mid-word: R9
    port_pcs = 4'b1111; cfg_div = 8'd4;
    host_write(1'b0, 4'd3, 16'h0010); host_write(1'b1, 4'd3, 16'hFFFF);
    @(negedge clk); start_ptr = 4'd3; end_ptr = 4'd3; go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 running before fault", busy, 1'b1);
    ss_n = 1'b0;
    @(negedge clk);
    ss_n = 1'b1;
    chk("R9 busy cleared by fault", busy, 1'b0);
    chk("R9 fault flag set", mode_fault, 1'b1);
    chk("R9 pcs back to port", pcs, port_pcs);
    chk("R9 sck back to port", sck, port_sck);
    repeat (60) @(negedge clk);
    chk("R9 fault sticky", mode_fault, 1'b1);
    read_rx(4'd3, r); chk("R9 aborted slot not written", r, 16'h0135);

    // go while fault set: R10
    go = 1'b1; @(negedge clk); go = 1'b0;
    chk("R10 go ignored under fault", busy, 1'b0);

    // set vs clear in same cycle: R9
    ss_n = 1'b0; fault_clr = 1'b1; @(negedge clk); ss_n = 1'b1; fault_clr = 1'b0;
    chk("R9 set wins over clear", mode_fault, 1'b1);
    fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
    chk("R9 clear alone", mode_fault, 1'b0);

    // fault vs go in same cycle: R9
    go = 1'b1; ss_n = 1'b0; @(negedge clk); go = 1'b0; ss_n = 1'b1;
    chk("R9 fault wins over go (busy)", busy, 1'b0);
    chk("R9 fault wins over go (flag)", mode_fault, 1'b1);
    fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;

    // not in master mode: R9, R10
    master_en = 1'b0; ss_n = 1'b0; @(negedge clk); ss_n = 1'b1;
    chk("R9 no fault without master mode", mode_fault, 1'b0);
    go = 1'b1; @(negedge clk); go = 1'b0;
    chk("R10 go ignored without master mode", busy, 1'b0);
    master_en = 1'b1;

    // ---- open-drain drive: R11
    wired_or = 1'b1; port_sck = 1'b1; port_mosi = 1'b0; port_pcs = 4'b1010;
    @(negedge clk);
    chk("R11 sck_oe open-drain", sck_oe, 1'b0);
    chk("R11 mosi_oe open-drain", mosi_oe, 1'b1);
    chk("R11 pcs_oe open-drain", pcs_oe, 4'b0101);
    chk("R8 idle mosi = port", mosi, 1'b0);
    wired_or = 1'b0;
    @(negedge clk);
    chk("R11 push-pull enables", {sck_oe, mosi_oe, pcs_oe}, 6'b111111);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule